// File: doc/BRIEF.md
# Oversampling Serial Receiver and Transmitter with Echo Path

This block is an asynchronous serial link endpoint carrying 8-bit characters. The line idles high. A frame is a low start bit, then the data bits with the least significant bit first, then one high stop bit. There is no parity. A shared divider produces a sample tick at sixteen times the bit rate. The receiver uses that tick to cut each bit into sixteen slices. The value of each bit is taken as the 2-of-3 majority of the three central slices, not from a single mid-point sample.

The top level wires the receiver to the transmitter as an echo path. Each character that arrives intact is transmitted back unchanged on the serial output. If a character completes while the transmitter is still busy with the previous one, the new character is not echoed and a one-cycle overrun pulse is raised instead. The received character and its strobe are still presented at the ports.

The line input is resynchronised through two flip-flops before any sampling. The divider ratio, the oversampling factor and the character width are parameters.

Top module: `uart_loopback`

## Requirements
- R1: After a synchronous reset, `tx_o` is 1, `tx_busy_o` is 0, and `rx_valid_o`, `frame_err_o` and `overrun_o` are 0.
- R2: A well-formed frame (low start bit, data bits LSB first at 16 ticks each, high stop bit) produces exactly one `rx_valid_o` pulse, with `rx_data_o` equal to the sent character.
- R3: The receiver samples each bit at three central tick slices and keeps the majority. A disturbance that corrupts at most one of those slices does not change the received bit.
- R4: A falling edge followed by a start bit that votes high is treated as noise. The receiver returns to idle with no strobe, no framing error and no echo.
- R5: A stop bit that votes low gives a one-cycle `frame_err_o` pulse and no `rx_valid_o`. `rx_valid_o` and `frame_err_o` are never high together.
- R6: Each character received while the transmitter is idle is sent back on `tx_o` unchanged, as a full frame of 16 × CLKS_PER_TICK clocks per bit, and the transmitter turns busy on the next clock.
- R7: `tx_busy_o` is high for the whole echoed frame and falls only on a sample tick, after the stop bit.
- R8: If a character is received while `tx_busy_o` is high, that character is not transmitted and `overrun_o` pulses for exactly one cycle.
- R9: `rx_valid_o` is a single-cycle pulse for each received character.
- R10: `tx_o` is high whenever the transmitter is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Asynchronous serial line in |
| tx_o | output | 1 | Serial line out (echo) |
| rx_valid_o | output | 1 | One-cycle strobe: character received |
| rx_data_o | output | DATA_BITS | Last received character |
| frame_err_o | output | 1 | One-cycle pulse: stop bit voted low |
| overrun_o | output | 1 | One-cycle pulse: character dropped, transmitter busy |
| tx_busy_o | output | 1 | Transmitter is sending a frame |

## Verification
Some properties are checked on every cycle by the assertions. These are that the strobes last a single cycle, that a good character and a framing error never coincide, that the idle line stays high, that busy can only fall on a tick, and that an accepted echo sets busy on the next clock. Other behaviour needs whole frames of line activity, and only the bench scenarios can show it. This covers the majority vote shrugging off short disturbances, rejection of a false start, the missing strobe on a bad stop bit, the exact character echoed on the line, and a dropped echo when frames arrive with shortened stop bits.

// File: rtl/uart_pkg.sv
package uart_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  // 2-of-3 majority over the centre slices of one bit
  function automatic logic vote3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction

endpackage

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_i,
  input  logic                 rx_i,
  output logic                 valid_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 ferr_o
);
  localparam int CW = $clog2(OSR);
  localparam int IW = $clog2(DATA_BITS);
  localparam logic [CW-1:0] S_FIRST = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] S_LAST  = CW'(OSR / 2 + 1);
  localparam logic [CW-1:0] DECIDE  = CW'(OSR / 2 + 2);
  localparam logic [CW-1:0] SLICE_END = CW'(OSR - 1);
  localparam logic [IW-1:0] IDX_END = IW'(DATA_BITS - 1);

  logic [1:0]           sync_q;
  logic                 rx_s;
  rx_state_e            state_q;
  logic [CW-1:0]        cnt_q;
  logic [2:0]           votes_q;
  logic [IW-1:0]        idx_q;
  logic [DATA_BITS-1:0] shreg_q;
  logic                 seen_high_q;
  logic                 bit_val;

  assign rx_s    = sync_q[1];
  assign bit_val = vote3(votes_q);

  // two-flop resynchroniser, resets to idle level
  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], rx_i};
  end

  // centre-slice capture
  always_ff @(posedge clk) begin
    if (rst) begin
      votes_q <= 3'b111;
    end else if (tick_i && state_q != RX_IDLE && cnt_q >= S_FIRST && cnt_q <= S_LAST) begin
      votes_q <= {votes_q[1:0], rx_s};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= RX_IDLE;
      cnt_q       <= '0;
      idx_q       <= '0;
      shreg_q     <= '0;
      seen_high_q <= 1'b0;
      valid_o     <= 1'b0;
      ferr_o      <= 1'b0;
      data_o      <= '0;
    end else begin
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
      if (state_q == RX_IDLE) begin
        if (!rx_s && seen_high_q) begin
          state_q     <= RX_START;
          cnt_q       <= '0;
          seen_high_q <= 1'b0;
        end else if (rx_s) begin
          seen_high_q <= 1'b1;
        end
      end else begin
        seen_high_q <= rx_s;
        if (tick_i) begin
          cnt_q <= (cnt_q == SLICE_END) ? '0 : cnt_q + 1'b1;
          unique case (state_q)
            RX_START: begin
              if (cnt_q == DECIDE && bit_val) begin
                state_q <= RX_IDLE;
              end else if (cnt_q == SLICE_END) begin
                state_q <= RX_DATA;
                idx_q   <= '0;
              end
            end
            RX_DATA: begin
              if (cnt_q == DECIDE) begin
                shreg_q <= {bit_val, shreg_q[DATA_BITS-1:1]};
              end else if (cnt_q == SLICE_END) begin
                if (idx_q == IDX_END) state_q <= RX_STOP;
                else                  idx_q   <= idx_q + 1'b1;
              end
            end
            RX_STOP: begin
              if (cnt_q == DECIDE) begin
                state_q <= RX_IDLE;
                if (bit_val) begin
                  valid_o <= 1'b1;
                  data_o  <= shreg_q;
                end else begin
                  ferr_o <= 1'b1;
                end
              end
            end
            default: state_q <= RX_IDLE;
          endcase
        end
      end
    end
  end

  a_r9_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  a_r5_valid_ferr_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(valid_o && ferr_o));
  a_r5_ferr_pulse: assert property (@(posedge clk) disable iff (rst)
    ferr_o |=> !ferr_o);
endmodule

// File: rtl/uart_tx.sv
module uart_tx #(
  parameter int OSR       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_i,
  input  logic                 start_i,
  input  logic [DATA_BITS-1:0] data_i,
  output logic                 tx_o,
  output logic                 busy_o
);
  localparam int FRAME = DATA_BITS + 2;
  localparam int CW    = $clog2(OSR);
  localparam int BW    = $clog2(FRAME + 1);
  localparam logic [CW-1:0] SLICE_END = CW'(OSR - 1);

  logic [FRAME-1:0] shreg_q;
  logic [CW-1:0]    cnt_q;
  logic [BW-1:0]    left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '1;
      cnt_q   <= '0;
      left_q  <= '0;
      tx_o    <= 1'b1;
      busy_o  <= 1'b0;
    end else if (!busy_o) begin
      if (start_i) begin
        shreg_q <= {1'b1, data_i, 1'b0};
        cnt_q   <= '0;
        left_q  <= BW'(FRAME);
        tx_o    <= 1'b0;
        busy_o  <= 1'b1;
      end
    end else if (tick_i) begin
      if (cnt_q == SLICE_END) begin
        cnt_q <= '0;
        if (left_q == BW'(1)) begin
          busy_o <= 1'b0;
          tx_o   <= 1'b1;
        end else begin
          shreg_q <= {1'b1, shreg_q[FRAME-1:1]};
          tx_o    <= shreg_q[1];
          left_q  <= left_q - 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  a_r10_idle_line_high: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> tx_o);
  a_r7_busy_falls_on_tick: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !tick_i) |=> busy_o);
endmodule

// File: rtl/uart_loopback.sv
module uart_loopback #(
  parameter int CLKS_PER_TICK = 4,
  parameter int OSR           = 16,
  parameter int DATA_BITS     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_i,
  output logic                 tx_o,
  output logic                 rx_valid_o,
  output logic [DATA_BITS-1:0] rx_data_o,
  output logic                 frame_err_o,
  output logic                 overrun_o,
  output logic                 tx_busy_o
);
  logic tick;
  logic echo_start;

  uart_tick_gen #(.DIV(CLKS_PER_TICK)) tick_i (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  uart_rx #(.OSR(OSR), .DATA_BITS(DATA_BITS)) rx_u (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick),
    .rx_i    (rx_i),
    .valid_o (rx_valid_o),
    .data_o  (rx_data_o),
    .ferr_o  (frame_err_o)
  );

  assign echo_start = rx_valid_o && !tx_busy_o;

  uart_tx #(.OSR(OSR), .DATA_BITS(DATA_BITS)) tx_u (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick),
    .start_i (echo_start),
    .data_i  (rx_data_o),
    .tx_o    (tx_o),
    .busy_o  (tx_busy_o)
  );

  always_ff @(posedge clk) begin
    if (rst) overrun_o <= 1'b0;
    else     overrun_o <= rx_valid_o && tx_busy_o;
  end

  a_r6_echo_sets_busy: assert property (@(posedge clk) disable iff (rst)
    (rx_valid_o && !tx_busy_o) |=> tx_busy_o);
  a_r8_overrun_pulse: assert property (@(posedge clk) disable iff (rst)
    overrun_o |=> !overrun_o);
  a_r8_overrun_keeps_frame: assert property (@(posedge clk) disable iff (rst)
    (rx_valid_o && tx_busy_o && !tick) |=> tx_busy_o);
endmodule

// File: tb/uart_loopback_tb_top.sv
module uart_loopback_tb_top;
  localparam int TICK = 4;
  localparam int BITC = 16 * TICK;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx  = 1'b1;
  logic       tx_o, rx_valid, frame_err, overrun, tx_busy;
  logic [7:0] rx_data;

  int checks = 0, errors = 0;
  int rx_cnt = 0, ferr_cnt = 0, ovr_cnt = 0, tx_cnt = 0;
  logic [7:0] rx_last = 8'h00;
  logic [7:0] tx_last = 8'h00;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_loopback #(.CLKS_PER_TICK(TICK), .OSR(16), .DATA_BITS(8)) dut_i (
    .clk(clk), .rst(rst), .rx_i(rx), .tx_o(tx_o), .rx_valid_o(rx_valid),
    .rx_data_o(rx_data), .frame_err_o(frame_err), .overrun_o(overrun),
    .tx_busy_o(tx_busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // event monitors sampled on the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin rx_cnt++; rx_last = rx_data; end
      if (frame_err) ferr_cnt++;
      if (overrun) ovr_cnt++;
    end
  end

  // serial decoder for the echo line
  initial begin
    logic [7:0] b;
    wait (rst == 1'b0);
    forever begin
      @(negedge clk);
      if (tx_o == 1'b0) begin
        repeat (BITC / 2) @(negedge clk);
        check(tx_o == 1'b0, "R6 start bit", tx_o, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (BITC) @(negedge clk);
          b[i] = tx_o;
        end
        repeat (BITC) @(negedge clk);
        check(tx_o == 1'b1, "R6 stop bit", tx_o, 1);
        tx_last = b;
        tx_cnt++;
      end
    end
  end

  task automatic idle(input int n);
    rx = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input int stop_clks, input logic stop_lvl,
                      input bit glitch);
    rx = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      if (glitch) begin
        rx = b[i];
        repeat (30 + 2 * i) @(negedge clk);
        rx = ~b[i];
        repeat (2) @(negedge clk);
        rx = b[i];
        repeat (BITC - 32 - 2 * i) @(negedge clk);
      end else begin
        rx = b[i];
        repeat (BITC) @(negedge clk);
      end
    end
    rx = stop_lvl;
    repeat (stop_clks) @(negedge clk);
    rx = 1'b1;
  endtask

  task automatic echo_byte(input logic [7:0] b, input bit glitch, input string req);
    int rc, tc;
    rc = rx_cnt; tc = tx_cnt;
    send(b, BITC, 1'b1, glitch);
    idle(8);
    check(tx_busy == 1'b1, "R7 busy during echo", tx_busy, 1);
    idle(720);
    check(rx_cnt == rc + 1, {req, " strobe count"}, rx_cnt, rc + 1);
    check(rx_last == b, {req, " data"}, rx_last, b);
    check(tx_cnt == tc + 1 && tx_last == b, "R6 echoed byte", tx_last, b);
    check(tx_busy == 1'b0 && tx_o == 1'b1, "R10 idle line high", {tx_busy, tx_o}, 1);
  endtask

  initial begin
    int rc, fc, tc, oc;
    void'($urandom(32'd4242));
    repeat (10) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(tx_o == 1'b1, "R1 tx idle", tx_o, 1);
    check(tx_busy == 1'b0, "R1 busy low", tx_busy, 0);
    check({rx_valid, frame_err, overrun} == 3'b000, "R1 strobes low",
          {rx_valid, frame_err, overrun}, 0);
    idle(100);

    // R2 directed and random characters
    echo_byte(8'hA5, 1'b0, "R2");
    echo_byte(8'h00, 1'b0, "R2");
    echo_byte(8'hFF, 1'b0, "R2");
    for (int k = 0; k < 12; k++) echo_byte(8'($urandom), 1'b0, "R2");

    // R3 single-slice disturbances do not alter the vote
    echo_byte(8'h3C, 1'b1, "R3");
    echo_byte(8'hC9, 1'b1, "R3");

    // R4 short low pulse is a false start
    rc = rx_cnt; fc = ferr_cnt; tc = tx_cnt;
    rx = 1'b0;
    repeat (8) @(negedge clk);
    idle(1500);
    check(rx_cnt == rc, "R4 no strobe on noise", rx_cnt, rc);
    check(ferr_cnt == fc, "R4 no framing error on noise", ferr_cnt, fc);
    check(tx_cnt == tc, "R4 no echo on noise", tx_cnt, tc);
    echo_byte(8'h5A, 1'b0, "R4 recovery");

    // R5 low stop bit
    rc = rx_cnt; fc = ferr_cnt; tc = tx_cnt;
    send(8'h55, BITC, 1'b0, 1'b0);
    idle(800);
    check(ferr_cnt == fc + 1, "R5 framing error pulse", ferr_cnt, fc + 1);
    check(rx_cnt == rc, "R5 no strobe", rx_cnt, rc);
    check(tx_cnt == tc, "R5 no echo", tx_cnt, tc);
    echo_byte(8'h81, 1'b0, "R5 recovery");

    // R8 second character arrives while echo still running
    rc = rx_cnt; tc = tx_cnt; oc = ovr_cnt;
    send(8'h11, 48, 1'b1, 1'b0);
    send(8'h22, BITC, 1'b1, 1'b0);
    idle(1500);
    check(rx_cnt == rc + 2, "R8 both received", rx_cnt, rc + 2);
    check(rx_last == 8'h22, "R8 second data", rx_last, 8'h22);
    check(ovr_cnt == oc + 1, "R8 overrun pulse", ovr_cnt, oc + 1);
    check(tx_cnt == tc + 1 && tx_last == 8'h11, "R8 only first echoed", tx_last, 8'h11);
    check(tx_o == 1'b1, "R10 idle after overrun", tx_o, 1);
    echo_byte(8'h7E, 1'b0, "R9 single strobe");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule